// File: doc/BRIEF.md
# Line-Doubled Scanout Address Generator

This block streams one display line of pixel bytes from a linear framebuffer to a byte-wide parallel output port. A line-start pulse begins a transfer of a fixed number of bytes, 160 by default. The bytes are read one at a time through a synchronous memory read port, starting at the current line base address. They are presented on the output with a one-cycle valid strobe, one byte every three clock cycles. This pacing lets a full line fit inside a 960-cycle active window.

When a line finishes, the block raises a one-cycle completion pulse. In the same cycle it inspects the line counter, which already names the next line. If that count is even, the base address moves forward by one line. If it is odd, the base is kept, so the next line sends the same row again. Each stored row is therefore shown on two consecutive scan lines. The base wraps to zero when the advanced value reaches the framebuffer size, 40960 bytes by default, so no software reload is needed.

Top module: `scan_addr_gen`

## Requirements
- R1: After reset no transfer is active: `mem_rd`, `pix_valid` and `block_done` are low, and the first accepted line reads from base address 0.
- R2: A `line_start` pulse sampled while idle starts a transfer of exactly LINE_BYTES (160) reads at consecutive addresses base, base+1, …, base+159.
- R3: The first read is issued in the cycle after `line_start` is sampled. Reads are spaced exactly CYC_PER_BYTE (3) cycles apart. `pix_valid` is high exactly one cycle after each `mem_rd`, with `pix_data` equal to the byte the memory returned for that address.
- R4: `block_done` is a single-cycle pulse that coincides with the valid strobe of the last byte of the line, once per line.
- R5: If bit 0 of `line_count` is 0 in the `block_done` cycle, the base address advances by LINE_BYTES; at all other times the base is unchanged.
- R6: If bit 0 of `line_count` is 1 in the `block_done` cycle, the base address is kept, and the next line repeats the same bytes.
- R7: When base + LINE_BYTES would be greater than or equal to FB_BYTES (40960), the base becomes 0 instead.
- R8: A `line_start` that arrives while a transfer is running, including the `block_done` cycle, is ignored. The running line is not restarted, and no further reads follow the completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | Line-start trigger |
| line_count | input | LCNT_W (10) | Current line counter; bit 0 gives the parity of the next line |
| mem_addr | output | ADDR_W (16) | Framebuffer read address |
| mem_rd | output | 1 | Read strobe; data is returned one cycle later |
| mem_rdata | input | 8 | Read data from framebuffer memory |
| pix_data | output | 8 | Pixel byte to the parallel port |
| pix_valid | output | 1 | `pix_data` is valid this cycle |
| block_done | output | 1 | Last byte of the line is on the output |

## Verification
Two events can fall in the same cycle: the completion pulse, which also commits the base update, and a new line-start trigger. The bench raises `line_start` exactly in the cycle where it observes `block_done`. It then checks that no read and no valid strobe follow for several cycles. The next accepted line must start at the base implied by the parity of that line. A second case pokes the trigger in the middle of a line and checks that the byte sequence continues unbroken, with a single completion.

// File: rtl/scan_pkg.sv
// Shared definitions for the scanout address generator.
// Assumes: pixels are one byte wide.
package scan_pkg;
    localparam int PIX_W = 8;

    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_RUN   = 2'd1,
        SC_DRAIN = 2'd2
    } scan_state_e;
endpackage

// File: rtl/scan_pacer.sv
// Byte pacer: counts cycles within a byte slot and the byte index within
// a line. Assumes clear and run are never high together.
module scan_pacer #(
    parameter int LINE_BYTES   = 160,
    parameter int CYC_PER_BYTE = 3,
    parameter int IDX_W        = 8,
    parameter int PACE_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    output logic [IDX_W-1:0] idx,
    output logic             pace_zero,
    output logic             last_byte
);
    logic step;

    generate
        if (CYC_PER_BYTE > 1) begin : g_paced
            logic [PACE_W-1:0] pace_q;
            // Slot cycle counter, wraps every CYC_PER_BYTE cycles.
            always_ff @(posedge clk) begin
                if (!rst_n || clear)
                    pace_q <= '0;
                else if (run)
                    pace_q <= (pace_q == PACE_W'(CYC_PER_BYTE - 1)) ? '0 : pace_q + 1'b1;
            end
            assign step      = (pace_q == PACE_W'(CYC_PER_BYTE - 1));
            assign pace_zero = (pace_q == '0);
        end else begin : g_every
            assign step      = 1'b1;
            assign pace_zero = 1'b1;
        end
    endgenerate

    // Byte index within the current line.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            idx <= '0;
        else if (run && step)
            idx <= idx + 1'b1;
    end

    assign last_byte = (idx == IDX_W'(LINE_BYTES - 1));
endmodule

// File: rtl/scan_base.sv
// Line base register: on an update strobe it either advances by one line,
// wrapping at the framebuffer size, or holds for a repeated line.
// Assumes FB_BYTES fits in ADDR_W bits.
module scan_base #(
    parameter int LINE_BYTES = 160,
    parameter int FB_BYTES   = 40960,
    parameter int ADDR_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              update,
    input  logic              advance,
    output logic [ADDR_W-1:0] base
);
    logic [ADDR_W:0]   sum;
    logic [ADDR_W-1:0] next_base;

    // Candidate next base with wrap at the framebuffer end.
    always_comb begin
        sum = {1'b0, base} + (ADDR_W + 1)'(LINE_BYTES);
        if (sum >= (ADDR_W + 1)'(FB_BYTES))
            next_base = '0;
        else
            next_base = sum[ADDR_W-1:0];
    end

    // Base register, changed only on an advancing update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base <= '0;
        else if (update && advance)
            base <= next_base;
    end
endmodule

// File: rtl/scan_seq.sv
// Transfer sequencer: accepts a trigger only when idle, issues paced reads,
// then spends one drain cycle in which the completion pulse is shown.
// Assumes the memory returns data one cycle after a read.
module scan_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    input  logic pace_zero,
    input  logic last_byte,
    output logic accept,
    output logic running,
    output logic rd,
    output logic valid_q,
    output logic done_q
);
    import scan_pkg::*;

    scan_state_e state_q;

    assign accept  = (state_q == SC_IDLE) && line_start;
    assign running = (state_q == SC_RUN);
    assign rd      = running && pace_zero;

    // State progression: idle -> run -> drain -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SC_IDLE;
        else begin
            case (state_q)
                SC_IDLE:  if (line_start) state_q <= SC_RUN;
                SC_RUN:   if (pace_zero && last_byte) state_q <= SC_DRAIN;
                SC_DRAIN: state_q <= SC_IDLE;
                default:  state_q <= SC_IDLE;
            endcase
        end
    end

    // Valid and completion strobes, aligned with the returned data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            valid_q <= rd;
            done_q  <= rd && last_byte;
        end
    end
endmodule

// File: rtl/scan_addr_gen.sv
// Line-doubled scanout address generator top. Streams LINE_BYTES bytes per
// line-start from the current base; advances the base after lines whose
// following line number is even. Assumes a one-cycle synchronous memory.
module scan_addr_gen #(
    parameter int LINE_BYTES   = 160,
    parameter int FB_BYTES     = 40960,
    parameter int CYC_PER_BYTE = 3,
    parameter int LCNT_W       = 10,
    parameter int ADDR_W       = $clog2(FB_BYTES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       line_start,
    input  logic [LCNT_W-1:0]          line_count,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic                       mem_rd,
    input  logic [scan_pkg::PIX_W-1:0] mem_rdata,
    output logic [scan_pkg::PIX_W-1:0] pix_data,
    output logic                       pix_valid,
    output logic                       block_done
);
    localparam int IDX_W  = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 1;
    localparam int PACE_W = (CYC_PER_BYTE > 1) ? $clog2(CYC_PER_BYTE) : 1;

    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] base_w;
    logic              pace_zero, last_byte, accept, running, next_even;

    assign next_even = ((line_count & LCNT_W'(1)) == '0);

    scan_pacer #(
        .LINE_BYTES(LINE_BYTES), .CYC_PER_BYTE(CYC_PER_BYTE),
        .IDX_W(IDX_W), .PACE_W(PACE_W)
    ) u_pacer (
        .clk(clk), .rst_n(rst_n), .clear(accept), .run(running),
        .idx(idx), .pace_zero(pace_zero), .last_byte(last_byte)
    );

    scan_seq u_seq (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .pace_zero(pace_zero), .last_byte(last_byte),
        .accept(accept), .running(running), .rd(mem_rd),
        .valid_q(pix_valid), .done_q(block_done)
    );

    scan_base #(
        .LINE_BYTES(LINE_BYTES), .FB_BYTES(FB_BYTES), .ADDR_W(ADDR_W)
    ) u_base (
        .clk(clk), .rst_n(rst_n), .update(block_done),
        .advance(next_even), .base(base_w)
    );

    assign mem_addr = base_w + ADDR_W'(idx);
    assign pix_data = mem_rdata;
endmodule

// File: rtl/scan_checker.sv
// Property checker for scan_addr_gen, attached by bind.
module scan_checker #(
    parameter int LINE_BYTES   = 160,
    parameter int FB_BYTES     = 40960,
    parameter int CYC_PER_BYTE = 3,
    parameter int ADDR_W       = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic              pix_valid,
    input logic              block_done,
    input logic              lc_lsb,
    input logic [ADDR_W-1:0] base
);
    generate
        if (CYC_PER_BYTE > 1) begin : g_gap
            p_rd_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
                mem_rd |=> !mem_rd);
        end
    endgenerate

    p_valid_after_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> pix_valid);

    p_valid_needs_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(mem_rd));

    p_done_on_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |-> pix_valid);

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |=> !block_done);

    p_base_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !block_done |=> $stable(base));

    p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (block_done && !lc_lsb && (int'(base) + LINE_BYTES < FB_BYTES))
        |=> (int'(base) == int'($past(base)) + LINE_BYTES));

    p_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (block_done && lc_lsb) |=> $stable(base));

    p_base_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(base) < FB_BYTES);
endmodule

bind scan_addr_gen scan_checker #(
    .LINE_BYTES(LINE_BYTES), .FB_BYTES(FB_BYTES),
    .CYC_PER_BYTE(CYC_PER_BYTE), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .pix_valid(pix_valid),
    .block_done(block_done), .lc_lsb(line_count[0]), .base(base_w)
);

// File: tb/sim_scan_addr_gen.sv
module sim_scan_addr_gen;
    localparam int LINE = 160;
    localparam int FB   = 40960;
    localparam int CPB  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic [9:0]  line_count = '0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  pix_data;
    logic        pix_valid;
    logic        block_done;

    int checks = 0;
    int failures = 0;
    int exp_base = 0;
    int cycles = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    scan_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_count(line_count),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .pix_data(pix_data), .pix_valid(pix_valid), .block_done(block_done)
    );

    function automatic logic [7:0] pat(input int a);
        logic [15:0] w;
        w = 16'(a);
        return w[7:0] ^ w[15:8] ^ 8'h5A;
    endfunction

    // Framebuffer model with one cycle of read latency.
    always @(posedge clk) if (mem_rd) mem_rdata <= pat(int'(mem_addr));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One full line: checks addresses, data, pacing, completion and quiet tail.
    task automatic run_line(input int lc, input bit poke_mid, input bit poke_done, input string tag);
        int nrd = 0, nval = 0, ndone = 0, cyc = 1, last_v = -1, first = -1;
        int bad_addr = 0, bad_data = 0, bad_gap = 0, noise = 0;
        bit done_seen = 0;
        line_count = 10'(lc);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        while (!done_seen && cyc < 1000) begin
            if (mem_rd) begin
                if (int'(mem_addr) != exp_base + nrd) bad_addr++;
                nrd++;
            end
            if (pix_valid) begin
                if (pix_data != pat(exp_base + nval)) bad_data++;
                if (first < 0) first = cyc;
                else if (cyc - last_v != CPB) bad_gap++;
                last_v = cyc;
                nval++;
            end
            if (block_done) begin
                ndone++;
                done_seen = 1;
                check(pix_valid && nval == LINE, "R4 done with last byte", nval, LINE);
                if (poke_done) line_start = 1'b1;
            end
            if (poke_mid && cyc == 200) line_start = 1'b1;
            if (poke_mid && cyc == 201) line_start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        line_start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (mem_rd || pix_valid || block_done) noise++;
            @(negedge clk);
        end
        check(first == 2, {tag, " R3 first byte latency"}, first, 2);
        check(bad_addr == 0 && nrd == LINE, {tag, " R2 read addresses"}, nrd, LINE);
        check(bad_data == 0, {tag, " R3 pixel data"}, bad_data, 0);
        check(bad_gap == 0, {tag, " R3 byte spacing"}, bad_gap, 0);
        check(ndone == 1, {tag, " R4 single completion"}, ndone, 1);
        check(noise == 0, {tag, " R8 quiet after line"}, noise, 0);
        if ((lc % 2) == 0) begin
            exp_base = exp_base + LINE;
            if (exp_base >= FB) exp_base = 0;
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(!mem_rd && !pix_valid && !block_done, "R1 idle in reset",
              int'({mem_rd, pix_valid, block_done}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!mem_rd && !pix_valid && !block_done, "R1 idle after reset",
              int'({mem_rd, pix_valid, block_done}), 0);
        exp_base = 0;
    endtask

    task automatic t_doubling;
        run_line(1, 0, 0, "R1 first line at 0");
        run_line(1, 0, 0, "R6 odd repeats");
        run_line(2, 0, 0, "R5 even advances");
        run_line(3, 0, 0, "R5 base 160");
        check(exp_base == 160, "R5 model base", exp_base, 160);
    endtask

    task automatic t_ignored;
        run_line(4, 1, 0, "R8 mid poke");
        run_line(5, 0, 1, "R8 poke at done");
        run_line(7, 0, 0, "R6 repeat after poke");
    endtask

    task automatic t_wrap;
        while (exp_base != FB - LINE) run_line(0, 0, 0, "R5 climb");
        run_line(0, 0, 0, "R7 last row");
        check(exp_base == 0, "R7 model wrap", exp_base, 0);
        run_line(1, 0, 0, "R7 row after wrap at 0");
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !ended) begin
            ended = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_doubling();
        t_ignored();
        t_wrap();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule